// File: doc/BRIEF.md
# Segment-Table Bus Address Decoder

This block decodes every cycle of a CPU bus with a 16-bit data path and a 24-bit byte address. The address space is cut into 32 segments of 512 KB. A 32-entry table names the device that owns each segment. The upper five address bits index the table, so no chain of range comparators is needed. A boot-overlay input rewrites the lower sixteen entries. While it is set, ROM images appear at the bottom of the map so that the processor can fetch its start vectors. Once it is cleared, RAM takes the bottom 4 MB. The sixteen upper entries never change.

The block registers each bus cycle on the clock edge where the strobe is sampled, and then decodes it combinationally. Its outputs hold for the following clock period. It drives one select line per external device, a write-enable with its data byte, a peripheral register index, and a masked offset for RAM or ROM. It also returns fill data on the byte lanes it answers itself: unmapped reads, forced high bytes and the phase-read port. A small phase counter advances on every word access to either serial-controller window, and software can read that counter back.

Top module: `seg_bus_decoder`

## Requirements
- R1: With the overlay input high, the segments below 0x600000 alternate in 1 MB blocks. ROM is at 0x000000, 0x200000 and 0x400000, and the blocks between them are unassigned. RAM owns 0x600000 to 0x7FFFFF.
- R2: With the overlay input low, RAM owns 0x000000 to 0x3FFFFF and ROM owns 0x400000 to 0x4FFFFF. The range 0x500000 to 0x7FFFFF is unassigned.
- R3: The table comes out of reset in the overlay-high map. The overlay value sampled on the same edge as a bus cycle already governs that cycle.
- R4: The segments from 0x800000 up follow a fixed map whatever the overlay value:
  - 1 MB regions: unassigned at 0x800000, serial read/reset at 0x900000, unassigned at 0xA00000, serial write at 0xB00000, unassigned at 0xC00000, floppy controller at 0xD00000.
  - 512 KB regions: unassigned at 0xE00000, timer/IO adapter at 0xE80000, phase read at 0xF00000, unassigned at 0xF80000.
- R5: An unmapped read sets fill_data to 0xFFFF with fill_mask 2'b11 for a word access, or to 0x00FF with fill_mask 2'b01 for a byte access.
  - fill_mask bit 1 claims the high byte and bit 0 the low byte. fill_data bits outside the mask are zero.
  - Writes to unmapped space or to ROM assert no select, no write-enable and no fill.
- R6: A RAM cycle asserts dev_sel bit 0, and a ROM read asserts dev_sel bit 1. mem_off is the byte address ANDed with 2^RAM_AW-1 for RAM or with 2^ROM_AW-1 for ROM, so the memories mirror across their regions. mem_off is zero otherwise. RAM writes assert dev_write.
- R7: The timer/IO adapter (dev_sel bit 5) is selected on even-lane accesses, and the floppy controller (dev_sel bit 4) only on odd-byte accesses.
  - An odd-byte access is a byte access with address bit 0 set. A word access counts as even.
  - The opposite lane reads as unmapped.
  - dev_reg carries address bits [12:9] on every strobed cycle.
  - Peripheral writes assert dev_write with dev_wdata equal to the low data byte.
- R8: A word access to either serial window increments the phase counter, which wraps modulo 8 at the default width. It selects nothing, and a read returns 0xFFFF with fill_mask 2'b11.
- R9: In the serial read/reset window, a byte access behaves by lane:
  - An odd-byte access pulses ser_reset for the cycle and selects nothing; a read also returns 0x00FF on mask 2'b01.
  - An even-byte access selects the serial read port (dev_sel bit 2).
- R10: In the serial write window, accesses behave by lane and direction:
  - An odd-byte write selects dev_sel bit 3 with dev_write high and the low data byte.
  - An odd-byte read does the same with data 0xFF and returns 0x00FF on mask 2'b01.
  - An even-byte access reads as unmapped.
- R11: A read of the phase-read region returns the counter's low 3 bits in fill_data[2:0], with bits [7:3] zero. A word read also forces the high byte to 0xFF (mask 2'b11); a byte read uses mask 2'b01. A word read of the timer region forces the high byte to 0xFF on mask 2'b10. Writes to the phase-read region have no effect.
- R12: At most one dev_sel bit is high. When the strobe was low on the capturing edge, and during reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_strobe | input | 1 | Data strobe: a bus cycle is present this edge |
| bus_addr | input | 24 | Byte address |
| bus_read | input | 1 | 1 = read, 0 = write |
| bus_word | input | 1 | 1 = word access, 0 = byte access |
| bus_wdata | input | 8 | Low data byte for peripheral writes |
| overlay | input | 1 | Boot-overlay control |
| dev_sel | output | 6 | One-hot device select: 0 RAM, 1 ROM, 2 serial read, 3 serial write, 4 floppy, 5 timer |
| dev_write | output | 1 | Write enable to the selected device |
| dev_wdata | output | 8 | Byte written to the selected peripheral |
| dev_reg | output | 4 | Peripheral register index, address bits [12:9] |
| mem_off | output | OFF_W | Masked RAM or ROM byte offset |
| fill_data | output | 16 | Data the decoder drives itself |
| fill_mask | output | 2 | Byte lanes claimed by fill_data |
| ser_reset | output | 1 | Serial-controller reset pulse |

## Verification
A corrupted table entry shows up at the first access to that segment. That access raises the wrong select bit or returns a fill word where memory should answer. A stale overlay rewrite shows up on the very next cycle to the lower 8 MB. A phase counter that skips or sticks is hidden until the phase-read port is read. The bench therefore reads the phase after runs of serial word accesses, including across the wrap, and compares the count against its own tally. Lane-qualification faults show up only on the wrong-parity access, so every peripheral window is exercised on both lanes and in both directions.

// File: rtl/seg_dec_pkg.sv
package seg_dec_pkg;

    localparam int ADDR_W    = 24;
    localparam int DATA_W    = 16;
    localparam int SEG_W     = 5;
    localparam int NSEG      = 1 << SEG_W;
    localparam int SEG_LSB   = ADDR_W - SEG_W;
    localparam int NLOW      = NSEG / 2;        // entries the overlay rewrites
    localparam int REG_LSB   = 9;
    localparam int REG_W     = 4;
    localparam int PHS_OUT_W = 3;
    localparam int BYTE_W    = 8;

    localparam int SEL_W     = 6;
    localparam int SEL_RAM   = 0;
    localparam int SEL_ROM   = 1;
    localparam int SEL_SRD   = 2;
    localparam int SEL_SWR   = 3;
    localparam int SEL_FLOP  = 4;
    localparam int SEL_TMR   = 5;

    typedef enum logic [2:0] {
        DV_NONE = 3'd0,
        DV_RAM  = 3'd1,
        DV_ROM  = 3'd2,
        DV_SRD  = 3'd3,
        DV_SWR  = 3'd4,
        DV_FLOP = 3'd5,
        DV_TMR  = 3'd6,
        DV_PHS  = 3'd7
    } seg_dev_e;

    typedef struct packed {
        logic              vld;
        logic              rd;
        logic              word;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] wdata;
    } bus_cyc_t;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic              wr;
        logic [BYTE_W-1:0] wdat;
        logic [REG_W-1:0]  rsel;
        logic [DATA_W-1:0] fdat;
        logic [1:0]        fmask;
        logic              srst;
        logic              bump;
    } lane_out_t;

    // Owner of a segment for a given overlay setting.
    function automatic seg_dev_e seg_home(input logic [SEG_W-1:0] idx, input logic ovl);
        seg_dev_e d;
        d = DV_NONE;
        if (!idx[SEG_W-1]) begin
            if (ovl) begin
                if (idx < 5'd12) d = idx[1] ? DV_NONE : DV_ROM;
                else             d = DV_RAM;
            end else begin
                if (idx < 5'd8)       d = DV_RAM;
                else if (idx < 5'd10) d = DV_ROM;
                else                  d = DV_NONE;
            end
        end else begin
            case (idx)
                5'd18, 5'd19: d = DV_SRD;
                5'd22, 5'd23: d = DV_SWR;
                5'd26, 5'd27: d = DV_FLOP;
                5'd29:        d = DV_TMR;
                5'd30:        d = DV_PHS;
                default:      d = DV_NONE;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/seg_table.sv
module seg_table
    import seg_dec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             overlay,
    input  logic [SEG_W-1:0] rd_idx,
    output seg_dev_e         rd_dev
);

    typedef struct packed {
        logic                 ovl;
        seg_dev_e [NSEG-1:0]  ent;
    } tbl_t;

    tbl_t st_d, st_q;

    // Rewrite the lower half in one clock whenever the overlay changes.
    always_comb begin
        st_d     = st_q;
        st_d.ovl = overlay;
        if (overlay != st_q.ovl) begin
            for (int i = 0; i < NLOW; i++) begin
                st_d.ent[i] = seg_home(SEG_W'(i), overlay);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ovl <= 1'b1;
            for (int i = 0; i < NSEG; i++) begin
                st_q.ent[i] <= seg_home(SEG_W'(i), 1'b1);
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_dev = st_q.ent[rd_idx];

endmodule

// File: rtl/seg_phase_ctr.sv
module seg_phase_ctr #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bump,
    output logic [W-1:0] count
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (bump) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

endmodule

// File: rtl/seg_lane_decode.sv
module seg_lane_decode
    import seg_dec_pkg::*;
(
    input  logic                 vld,
    input  logic                 rd,
    input  logic                 word,
    input  logic                 a0,
    input  logic [REG_W-1:0]     reg_bits,
    input  logic [BYTE_W-1:0]    wbyte,
    input  seg_dev_e             dev,
    input  logic [PHS_OUT_W-1:0] phase,
    output lane_out_t            o
);

    logic              odd;
    logic [DATA_W-1:0] unm_dat;
    logic [1:0]        unm_msk;

    always_comb begin
        odd     = ~word & a0;
        unm_dat = '0;
        unm_msk = '0;
        if (rd) begin
            unm_dat = word ? 16'hFFFF : 16'h00FF;
            unm_msk = word ? 2'b11 : 2'b01;
        end

        o = '0;
        if (vld) begin
            o.rsel = reg_bits;
            unique case (dev)
                DV_NONE: begin
                    o.fdat  = unm_dat;
                    o.fmask = unm_msk;
                end
                DV_RAM: begin
                    o.sel[SEL_RAM] = 1'b1;
                    o.wr           = ~rd;
                end
                DV_ROM: begin
                    o.sel[SEL_ROM] = rd;
                end
                DV_FLOP: begin
                    if (odd) begin
                        o.sel[SEL_FLOP] = 1'b1;
                        o.wr            = ~rd;
                        o.wdat          = rd ? '0 : wbyte;
                    end else begin
                        o.fdat  = unm_dat;
                        o.fmask = unm_msk;
                    end
                end
                DV_TMR: begin
                    if (!odd) begin
                        o.sel[SEL_TMR] = 1'b1;
                        o.wr           = ~rd;
                        o.wdat         = rd ? '0 : wbyte;
                        if (rd && word) begin
                            o.fdat  = 16'hFF00;
                            o.fmask = 2'b10;
                        end
                    end else begin
                        o.fdat  = unm_dat;
                        o.fmask = unm_msk;
                    end
                end
                DV_SRD: begin
                    if (word) begin
                        o.bump  = 1'b1;
                        o.fdat  = unm_dat;
                        o.fmask = unm_msk;
                    end else if (odd) begin
                        o.srst  = 1'b1;
                        o.fdat  = unm_dat;
                        o.fmask = unm_msk;
                    end else begin
                        o.sel[SEL_SRD] = 1'b1;
                    end
                end
                DV_SWR: begin
                    if (word) begin
                        o.bump  = 1'b1;
                        o.fdat  = unm_dat;
                        o.fmask = unm_msk;
                    end else if (odd) begin
                        o.sel[SEL_SWR] = 1'b1;
                        o.wr           = 1'b1;
                        o.wdat         = rd ? 8'hFF : wbyte;
                        o.fdat         = unm_dat;
                        o.fmask        = unm_msk;
                    end else begin
                        o.fdat  = unm_dat;
                        o.fmask = unm_msk;
                    end
                end
                DV_PHS: begin
                    if (rd) begin
                        o.fdat  = {word ? 8'hFF : 8'h00, {(BYTE_W-PHS_OUT_W){1'b0}}, phase};
                        o.fmask = word ? 2'b11 : 2'b01;
                    end
                end
                default: o = '0;
            endcase
        end
    end

endmodule

// File: rtl/seg_bus_decoder.sv
module seg_bus_decoder
    import seg_dec_pkg::*;
#(
    parameter int RAM_AW  = 17,
    parameter int ROM_AW  = 16,
    parameter int PHASE_W = 3,
    parameter int OFF_W   = (RAM_AW > ROM_AW) ? RAM_AW : ROM_AW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_strobe,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_read,
    input  logic                 bus_word,
    input  logic [BYTE_W-1:0]    bus_wdata,
    input  logic                 overlay,
    output logic [SEL_W-1:0]     dev_sel,
    output logic                 dev_write,
    output logic [BYTE_W-1:0]    dev_wdata,
    output logic [REG_W-1:0]     dev_reg,
    output logic [OFF_W-1:0]     mem_off,
    output logic [DATA_W-1:0]    fill_data,
    output logic [1:0]           fill_mask,
    output logic                 ser_reset
);

    localparam logic [ADDR_W-1:0] RAM_MASK = ADDR_W'((64'd1 << RAM_AW) - 64'd1);
    localparam logic [ADDR_W-1:0] ROM_MASK = ADDR_W'((64'd1 << ROM_AW) - 64'd1);

    bus_cyc_t             cyc_d, cyc_q;
    seg_dev_e             seg_dev;
    lane_out_t            lane;
    logic [PHASE_W-1:0]   phase_full;

    always_comb begin
        cyc_d.vld   = bus_strobe;
        cyc_d.rd    = bus_read;
        cyc_d.word  = bus_word;
        cyc_d.addr  = bus_addr;
        cyc_d.wdata = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc_q <= '0;
        else        cyc_q <= cyc_d;
    end

    seg_table u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .overlay(overlay),
        .rd_idx (cyc_q.addr[ADDR_W-1:SEG_LSB]),
        .rd_dev (seg_dev)
    );

    seg_phase_ctr #(.W(PHASE_W)) u_phase (
        .clk  (clk),
        .rst_n(rst_n),
        .bump (lane.bump),
        .count(phase_full)
    );

    seg_lane_decode u_lane (
        .vld     (cyc_q.vld),
        .rd      (cyc_q.rd),
        .word    (cyc_q.word),
        .a0      (cyc_q.addr[0]),
        .reg_bits(cyc_q.addr[REG_LSB+REG_W-1:REG_LSB]),
        .wbyte   (cyc_q.wdata),
        .dev     (seg_dev),
        .phase   (phase_full[PHS_OUT_W-1:0]),
        .o       (lane)
    );

    always_comb begin
        mem_off = '0;
        if (lane.sel[SEL_RAM])      mem_off = OFF_W'(cyc_q.addr & RAM_MASK);
        else if (lane.sel[SEL_ROM]) mem_off = OFF_W'(cyc_q.addr & ROM_MASK);
    end

    assign dev_sel   = lane.sel;
    assign dev_write = lane.wr;
    assign dev_wdata = lane.wdat;
    assign dev_reg   = lane.rsel;
    assign fill_data = lane.fdat;
    assign fill_mask = lane.fmask;
    assign ser_reset = lane.srst;

endmodule

// File: rtl/seg_dec_chk.sv
module seg_dec_chk
    import seg_dec_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bus_strobe,
    input logic             bus_read,
    input logic [SEL_W-1:0] dev_sel,
    input logic             dev_write,
    input logic [1:0]       fill_mask,
    input logic             ser_reset
);

    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_sel_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $onehot0(dev_sel));

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !$past(bus_strobe) |-> (dev_sel == '0 && !dev_write && fill_mask == 2'b00 && !ser_reset));

    p_rom_read_only_r5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        dev_sel[SEL_ROM] |-> $past(bus_read));

    p_fill_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (fill_mask != 2'b00) |-> $past(bus_read));

    p_reset_no_sel_r9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ser_reset |-> (dev_sel == '0));

    p_write_target_r10: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        dev_write |-> (dev_sel != '0));

endmodule

bind seg_bus_decoder seg_dec_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_strobe(bus_strobe),
    .bus_read  (bus_read),
    .dev_sel   (dev_sel),
    .dev_write (dev_write),
    .fill_mask (fill_mask),
    .ser_reset (ser_reset)
);

// File: tb/sim_seg_bus_decoder.sv
module sim_seg_bus_decoder;
    import seg_dec_pkg::*;

    localparam int CLK_NS = 10;
    localparam int RAM_AW = 17;
    localparam int ROM_AW = 16;
    localparam int OFF_W  = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe = 1'b0;
    logic [23:0] addr = '0;
    logic        rd = 1'b0;
    logic        word = 1'b0;
    logic [7:0]  wdata = '0;
    logic        ovl = 1'b1;

    logic [5:0]       dev_sel;
    logic             dev_write;
    logic [7:0]       dev_wdata;
    logic [3:0]       dev_reg;
    logic [OFF_W-1:0] mem_off;
    logic [15:0]      fill_data;
    logic [1:0]       fill_mask;
    logic             ser_reset;

    seg_bus_decoder #(.RAM_AW(RAM_AW), .ROM_AW(ROM_AW), .PHASE_W(3)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_strobe(strobe), .bus_addr(addr),
        .bus_read(rd), .bus_word(word), .bus_wdata(wdata), .overlay(ovl),
        .dev_sel(dev_sel), .dev_write(dev_write), .dev_wdata(dev_wdata),
        .dev_reg(dev_reg), .mem_off(mem_off), .fill_data(fill_data),
        .fill_mask(fill_mask), .ser_reset(ser_reset)
    );

    always #(CLK_NS/2) clk = ~clk;

    int total = 0;
    int bad = 0;
    int mphase = 0;

    logic [5:0]       e_sel;
    logic             e_wr;
    logic [7:0]       e_wdat;
    logic [3:0]       e_reg;
    logic [OFF_W-1:0] e_off;
    logic [15:0]      e_fdat;
    logic [1:0]       e_fmask;
    logic             e_srst;
    logic             e_bump;

    // 0 none, 1 ram, 2 rom, 3 serial rd, 4 serial wr, 5 floppy, 6 timer, 7 phase
    function automatic int region(input logic [23:0] a, input logic o);
        if (a < 24'h800000) begin
            if (o) begin
                if (a < 24'h600000) return a[20] ? 0 : 2;
                return 1;
            end
            if (a < 24'h400000) return 1;
            if (a < 24'h500000) return 2;
            return 0;
        end
        if (a >= 24'h900000 && a < 24'hA00000) return 3;
        if (a >= 24'hB00000 && a < 24'hC00000) return 4;
        if (a >= 24'hD00000 && a < 24'hE00000) return 5;
        if (a >= 24'hE80000 && a < 24'hF00000) return 6;
        if (a >= 24'hF00000 && a < 24'hF80000) return 7;
        return 0;
    endfunction

    function automatic string tag_of(input logic [23:0] a, input logic o, input logic w);
        int r;
        r = region(a, o);
        if (a < 24'h800000) return o ? "R1" : "R2";
        case (r)
            3:       return w ? "R8" : "R9";
            4:       return w ? "R8" : "R10";
            5, 6:    return "R7";
            7:       return "R11";
            default: return "R4";
        endcase
    endfunction

    task automatic unmapped();
        if (rd) begin
            e_fdat  = word ? 16'hFFFF : 16'h00FF;
            e_fmask = word ? 2'b11 : 2'b01;
        end
    endtask

    task automatic model();
        logic odd;
        e_sel = '0; e_wr = 0; e_wdat = '0; e_reg = '0; e_off = '0;
        e_fdat = '0; e_fmask = '0; e_srst = 0; e_bump = 0;
        if (strobe) begin
            odd   = !word && addr[0];
            e_reg = addr[12:9];
            case (region(addr, ovl))
                1: begin e_sel[0] = 1; e_wr = !rd; e_off = OFF_W'(addr & 24'h01FFFF); end
                2: if (rd) begin e_sel[1] = 1; e_off = OFF_W'(addr & 24'h00FFFF); end
                3: begin
                    if (word) begin e_bump = 1; unmapped(); end
                    else if (odd) begin e_srst = 1; unmapped(); end
                    else e_sel[2] = 1;
                end
                4: begin
                    if (word) begin e_bump = 1; unmapped(); end
                    else if (odd) begin
                        e_sel[3] = 1; e_wr = 1; e_wdat = rd ? 8'hFF : wdata; unmapped();
                    end else unmapped();
                end
                5: if (odd) begin e_sel[4] = 1; e_wr = !rd; e_wdat = rd ? 8'h00 : wdata; end
                   else unmapped();
                6: if (!odd) begin
                       e_sel[5] = 1; e_wr = !rd; e_wdat = rd ? 8'h00 : wdata;
                       if (rd && word) begin e_fdat = 16'hFF00; e_fmask = 2'b10; end
                   end else unmapped();
                7: if (rd) begin
                       e_fdat  = {word ? 8'hFF : 8'h00, 5'd0, 3'(mphase)};
                       e_fmask = word ? 2'b11 : 2'b01;
                   end
                default: unmapped();
            endcase
        end
    endtask

    task automatic check(input string tag);
        logic [56:0] act, exp;
        act = {dev_sel, dev_write, dev_wdata, dev_reg, mem_off, fill_data, fill_mask, ser_reset};
        exp = {e_sel, e_wr, e_wdat, e_reg, e_off, e_fdat, e_fmask, e_srst};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s addr=%h rd=%0b word=%0b ovl=%0b actual=%h expected=%h",
                     tag, addr, rd, word, ovl, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge where the result is valid.
    task automatic bus(input logic [23:0] a, input logic r, input logic w,
                       input logic [7:0] d, input logic o, input string tag);
        strobe = 1; addr = a; rd = r; word = w; wdata = d; ovl = o;
        model();
        @(posedge clk);
        @(negedge clk);
        check(tag);
        if (e_bump) mphase = (mphase + 1) % 8;
    endtask

    task automatic idle(input string tag);
        strobe = 0;
        model();
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #(CLK_NS * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        model();
        check("R12");                       // outputs quiet in reset
        rst_n = 1;

        // R3: first cycle after reset uses the overlay map
        bus(24'h000000, 1, 0, 8'h00, 1, "R3");
        // R1: overlay map
        bus(24'h100000, 1, 1, 8'h00, 1, "R1");
        bus(24'h200010, 1, 1, 8'h00, 1, "R1");
        bus(24'h4FFFFE, 1, 1, 8'h00, 1, "R1");
        bus(24'h600000, 0, 1, 8'h00, 1, "R1");
        bus(24'h7FFFFE, 1, 1, 8'h00, 1, "R1");
        // R3: overlay change applies to the cycle sampled with it
        bus(24'h000000, 1, 1, 8'h00, 0, "R3");
        bus(24'h000002, 1, 1, 8'h00, 1, "R3");
        // R2: normal map
        bus(24'h3FFFFE, 1, 1, 8'h00, 0, "R2");
        bus(24'h400000, 1, 1, 8'h00, 0, "R2");
        bus(24'h500001, 1, 0, 8'h00, 0, "R2");
        // R5: ignored writes
        bus(24'h500000, 0, 1, 8'h33, 0, "R5");
        bus(24'h400002, 0, 1, 8'h44, 0, "R5");
        bus(24'h800000, 1, 1, 8'h00, 0, "R5");
        // R4: upper map independent of overlay
        bus(24'h900001, 1, 0, 8'h00, 0, "R4");
        bus(24'hE00000, 1, 0, 8'h00, 1, "R4");
        bus(24'hF80000, 1, 1, 8'h00, 0, "R4");
        // R6: mirroring offsets
        bus(24'h020004, 1, 1, 8'h00, 0, "R6");
        bus(24'h412345, 1, 0, 8'h00, 0, "R6");
        // R7: lane qualification and register index
        bus(24'hE81A00, 1, 0, 8'h00, 0, "R7");
        bus(24'hE80001, 1, 0, 8'h00, 0, "R7");
        bus(24'hE80400, 0, 0, 8'hA5, 0, "R7");
        bus(24'hD01E01, 0, 0, 8'h3C, 0, "R7");
        bus(24'hD00000, 1, 0, 8'h00, 0, "R7");
        bus(24'hD00000, 1, 1, 8'h00, 0, "R7");
        // R11: timer word read forces high byte
        bus(24'hE80000, 1, 1, 8'h00, 0, "R11");
        // R8: serial word accesses bump phase
        bus(24'h900000, 1, 1, 8'h00, 0, "R8");
        bus(24'hB00000, 0, 1, 8'h11, 0, "R8");
        bus(24'hF00000, 1, 0, 8'h00, 0, "R11");
        bus(24'hF00000, 1, 1, 8'h00, 0, "R11");
        bus(24'hF00000, 0, 1, 8'h77, 0, "R11");
        // R9: read/reset window byte lanes
        bus(24'h9FFFF9, 1, 0, 8'h00, 0, "R9");
        bus(24'h9FFFF9, 0, 0, 8'h00, 0, "R9");
        bus(24'h9FFFF8, 1, 0, 8'h00, 0, "R9");
        // R10: write window byte lanes
        bus(24'hBFFFF9, 0, 0, 8'h5A, 0, "R10");
        bus(24'hBFFFF9, 1, 0, 8'h00, 0, "R10");
        bus(24'hBFFFF8, 1, 0, 8'h00, 0, "R10");
        // R8: wrap of the phase counter
        for (int k = 0; k < 7; k++) bus(24'hA7FFFE - 24'h100000, 1, 1, 8'h00, 1, "R8");
        bus(24'hF00000, 1, 0, 8'h00, 1, "R8");
        idle("R12");

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            logic [23:0] a;
            logic r, w, o;
            a = 24'($urandom);
            if ($urandom_range(0, 3) == 0) a[12:1] = 12'hFFF;
            r = 1'($urandom);
            w = 1'($urandom);
            if (w) a[0] = 1'b0;
            o = ovl;
            if ($urandom_range(0, 15) == 0) o = ~ovl;
            if ($urandom_range(0, 7) == 0) idle("R12");
            else bus(a, r, w, 8'($urandom), o, tag_of(a, o, w));
        end
        bus(24'hF00001, 1, 0, 8'h00, ovl, "R11");
        idle("R12");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule